// File: doc/BRIEF.md
# Compare-Triggered Sync Pulse Generator

This block turns a single compare-match strobe from a time-base counter into a timed output pulse, such as a once-per-second marker. When the strobe arrives, the block waits a programmable start delay, drives a pulse of programmable width, and then either stops or repeats at a programmable period. All three values are counted in reference clock ticks, which here means cycles of `clk`.

A period of zero selects one-shot operation: one pulse per accepted trigger. A non-zero period keeps the pulse train running until software turns the block off. Two outputs share the same pulse timing. Each output has its own enable bit, and a global enable bit gates both of them. Each output also has a sticky status flag that records that a pulse began, and software clears it by writing a one.

A small word-wide register port sets the control, width, period and delay values and reads them back. Working out the next period boundary and loading the compare value belong to the time-base logic that drives `cmp1_hit`.

Top module: `sync_pulse_gen`

## Requirements
- R1: After a synchronous reset, both sync outputs and both status flags are 0, and every register reads back 0.
- R2: A write stores its data in the addressed register: control at address 0, width at 1, period at 2, start delay at 3. A read returns the addressed value on `rd_data` after the clock edge that samples `rd_en`. Unmapped addresses read 0.
- R3: In the control register, bit 0 is the global enable and bit n+1 enables output n. Output n can be high only while both bits are set.
- R4: Take a trigger sampled at edge k while the global enable is set and the generator is idle. With a start delay of D, the outputs first read high after edge k+D, so a delay of 0 starts the pulse at once.
- R5: Each pulse is high for W consecutive cycles, where W is the width register. A width of 0 is treated as 1.
- R6: With a period of 0, exactly one pulse follows each accepted trigger, and the generator then returns to idle and waits for the next trigger.
- R7: With a period of P > 0, a new pulse starts every P cycles after the first one and continues until the global enable is cleared. If P ≤ W, the output stays high.
- R8: A trigger that arrives while the generator is busy is ignored and does not disturb the pulse timing. Busy means waiting out the delay, pulsing, or running periodically.
- R9: Consider a control write that clears the global enable, taking effect at edge e. Both outputs read 0 after edge e+1, and the generator returns to idle.
- R10: Status bit n, read at address 4, sets in the cycle that output n rises. Writing 1 to the bit clears it, but a rise in the same cycle wins over the clear.
- R11: A trigger is ignored while the global enable is clear, even if output enable bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| cmp1_hit | input | 1 | Compare-match trigger strobe |
| sync_o | output | 2 | Registered sync outputs |
| sync_sts | output | 2 | Sticky pulse-start status flags |

## Verification
All results are checked at a fixed number of edges after the stimulus. If a trigger is sampled at edge k, the bench expects output high after edge k+D exactly when the offset t−D (taken modulo P when P > 0) is below the effective width, and it compares at every falling edge from that point on. Read data is compared at the falling edge right after the sampling edge. A disable is checked one edge after the control write lands, because the enable goes through the control register before it reaches the generator. Delay, width and period are swept over small values, and each case is run for several output-enable masks. Retriggers are injected mid-pulse so that R8 is observed at the outputs.

// File: rtl/sync_pg_pkg.sv
package sync_pg_pkg;
  localparam int NUM_OUT   = 2;
  localparam int CTRL_W    = NUM_OUT + 1;
  localparam int A_CTRL    = 0;
  localparam int A_WIDTH   = 1;
  localparam int A_PERIOD  = 2;
  localparam int A_DELAY   = 3;
  localparam int A_STATUS  = 4;
  localparam int NUM_CNT   = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } gen_state_t;
endpackage

// File: rtl/sync_pg_regs.sv
module sync_pg_regs
  import sync_pg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_OUT-1:0] sts_in,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] width_q,
  output logic [DATA_W-1:0] period_q,
  output logic [DATA_W-1:0] delay_q,
  output logic [NUM_OUT-1:0] clr_mask
);
  logic [DATA_W-1:0] cnt_q [NUM_CNT];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  // Width, period and delay share one storage pattern at consecutive addresses.
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_WIDTH + i)) cnt_q[i] <= wr_data;
    end
  end

  assign width_q  = cnt_q[0];
  assign period_q = cnt_q[1];
  assign delay_q  = cnt_q[2];

  assign clr_mask = (wr_en && wr_addr == ADDR_W'(A_STATUS)) ? wr_data[NUM_OUT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      if (rd_addr == ADDR_W'(A_CTRL))        rd_data <= DATA_W'(ctrl_q);
      else if (rd_addr == ADDR_W'(A_WIDTH))  rd_data <= cnt_q[0];
      else if (rd_addr == ADDR_W'(A_PERIOD)) rd_data <= cnt_q[1];
      else if (rd_addr == ADDR_W'(A_DELAY))  rd_data <= cnt_q[2];
      else if (rd_addr == ADDR_W'(A_STATUS)) rd_data <= DATA_W'(sts_in);
      else                                   rd_data <= '0;
    end
  end

  // R2: a control write lands in the register at the next edge
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(A_CTRL)) |=> ctrl_q == $past(wr_data[CTRL_W-1:0]));
endmodule

// File: rtl/sync_pg_engine.sv
module sync_pg_engine
  import sync_pg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glob_en,
  input  logic             trig,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] delay,
  output logic             pulse_d
);
  gen_state_t st_q, st_d;
  logic [CNT_W-1:0] dly_q, dly_d, wid_q, wid_d, per_q, per_d;
  logic             pulse_q;
  logic             launch;
  logic [CNT_W-1:0] wid_load;

  assign wid_load = (width == '0) ? '0 : width - 1'b1;

  always_comb begin
    st_d    = st_q;
    dly_d   = dly_q;
    wid_d   = wid_q;
    per_d   = per_q;
    pulse_d = pulse_q;
    launch  = 1'b0;
    if (!glob_en) begin
      st_d    = ST_IDLE;
      pulse_d = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (trig) begin
            if (delay == '0) launch = 1'b1;
            else begin
              st_d  = ST_WAIT;
              dly_d = delay - 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (dly_q == '0) launch = 1'b1;
          else dly_d = dly_q - 1'b1;
        end
        ST_RUN: begin
          if (period != '0 && per_q == '0) launch = 1'b1;
          else begin
            if (period != '0) per_d = per_q - 1'b1;
            if (pulse_q) begin
              if (wid_q == '0) begin
                pulse_d = 1'b0;
                if (period == '0) st_d = ST_IDLE;
              end else begin
                wid_d = wid_q - 1'b1;
              end
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (launch) begin
        st_d    = ST_RUN;
        pulse_d = 1'b1;
        wid_d   = wid_load;
        per_d   = period - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      dly_q   <= '0;
      wid_q   <= '0;
      per_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      dly_q   <= dly_d;
      wid_q   <= wid_d;
      per_q   <= per_d;
      pulse_q <= pulse_d;
    end
  end

  // R6: an idle generator never holds the pulse
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> !pulse_q);
  // R9: clearing the global enable forces idle at the next edge
  p_disable_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !glob_en |=> (st_q == ST_IDLE && !pulse_q));
  // R5: a pulse only ends once its width count is used up
  p_width_end_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_q) && $past(glob_en)) |-> $past(wid_q) == '0);
  // R8: a retrigger during the delay does not restart the delay count
  p_retrig_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && dly_q != '0 && glob_en && trig) |=>
      (st_q == ST_WAIT && dly_q == $past(dly_q) - 1'b1));
endmodule

// File: rtl/sync_pg_outstage.sv
module sync_pg_outstage
  import sync_pg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pulse_d,
  input  logic [CTRL_W-1:0]  ctrl,
  input  logic [NUM_OUT-1:0] clr_mask,
  output logic [NUM_OUT-1:0] sync_q,
  output logic [NUM_OUT-1:0] sts_q
);
  logic [NUM_OUT-1:0] sync_d;

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    assign sync_d[n] = pulse_d & ctrl[0] & ctrl[n+1];

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q[n] <= 1'b0;
        sts_q[n]  <= 1'b0;
      end else begin
        sync_q[n] <= sync_d[n];
        sts_q[n]  <= (sts_q[n] & ~clr_mask[n]) | (sync_d[n] & ~sync_q[n]);
      end
    end

    // R3: an output is high only if its enables were set at the previous edge
    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
      sync_q[n] |-> $past(ctrl[0] & ctrl[n+1]));
    // R10: every rising output leaves its status flag set
    p_status_set_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(sync_q[n]) |-> sts_q[n]);
  end
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_pg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cmp1_hit,
  output logic [1:0]        sync_o,
  output logic [1:0]        sync_sts
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  width_q, period_q, delay_q;
  logic [NUM_OUT-1:0] clr_mask;
  logic               pulse_d;

  sync_pg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sts_in(sync_sts),
    .ctrl_q(ctrl_q), .width_q(width_q), .period_q(period_q), .delay_q(delay_q),
    .clr_mask(clr_mask)
  );

  sync_pg_engine #(.CNT_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst),
    .glob_en(ctrl_q[0]), .trig(cmp1_hit),
    .width(width_q), .period(period_q), .delay(delay_q),
    .pulse_d(pulse_d)
  );

  sync_pg_outstage u_out (
    .clk(clk), .rst(rst),
    .pulse_d(pulse_d), .ctrl(ctrl_q), .clr_mask(clr_mask),
    .sync_q(sync_o), .sts_q(sync_sts)
  );
endmodule

// File: tb/sim_sync_pulse_gen.sv
module sim_sync_pulse_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cmp1_hit = 1'b0;
  logic [1:0]  sync_o, sync_sts;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  sync_pulse_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmp1_hit(cmp1_hit), .sync_o(sync_o), .sync_sts(sync_sts)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // Expected single-output level t edges after the trigger edge.
  function automatic bit exp_lvl(int t, int d, int w, int p);
    int weff = (w == 0) ? 1 : w;
    if (t < d) return 1'b0;
    if (p == 0) return (t - d) < weff;
    return ((t - d) % p) < weff;
  endfunction

  task automatic run_case(input int d, input int w, input int p, input logic [2:0] ctl,
                          input int rt, input int n, input string req);
    logic [1:0]  mask;
    logic [31:0] v;
    logic [1:0]  e;
    mask = ctl[0] ? {ctl[2], ctl[1]} : 2'b00;
    wr(0, 0);
    wr(4, 3);
    wr(1, w); wr(2, p); wr(3, d);
    wr(0, {29'd0, ctl});
    @(negedge clk);
    cmp1_hit = 1'b1;
    @(posedge clk);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      if (t == 0 || t == rt + 1) cmp1_hit = 1'b0;
      if (t == rt) cmp1_hit = 1'b1;
      e = {2{exp_lvl(t, d, w, p)}} & mask;
      chk(req, {30'd0, sync_o}, {30'd0, e});
    end
    cmp1_hit = 1'b0;
    rd(4, v);
    chk("R10 status set", v, (n > d) ? {30'd0, mask} : 32'd0);
    wr(0, 0);
    @(negedge clk);
    chk("R9 disable", {30'd0, sync_o}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 stays off", {30'd0, sync_o}, 32'd0);
    wr(4, 3);
    rd(4, v);
    chk("R10 write-one clear", v, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 outputs", {30'd0, sync_o}, 32'd0);
    chk("R1 status", {30'd0, sync_sts}, 32'd0);
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk("R1 regs", v, 32'd0);
    end
    // R2 readback
    wr(1, 32'hA5A5_0013); rd(1, v); chk("R2 width", v, 32'hA5A5_0013);
    wr(2, 32'h0000_7777); rd(2, v); chk("R2 period", v, 32'h0000_7777);
    wr(3, 32'h1234_5678); rd(3, v); chk("R2 delay", v, 32'h1234_5678);
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 ctrl", v, 32'd7);
    rd(6, v); chk("R2 unmapped", v, 32'd0);
    wr(0, 0);
    // R4 R5 R6 one-shot sweep of delay and width
    for (int d = 0; d < 4; d++)
      for (int w = 0; w < 4; w++)
        run_case(d, w, 0, 3'b111, -5, 12, "R4 R5 R6 one-shot");
    // R3 per-output enables
    run_case(1, 2, 0, 3'b011, -5, 8, "R3 out0 only");
    run_case(1, 2, 0, 3'b101, -5, 8, "R3 out1 only");
    // R11 global enable off
    run_case(0, 3, 0, 3'b110, -5, 8, "R11 global off");
    // R8 retrigger during one-shot pulse
    run_case(2, 4, 0, 3'b111, 3, 14, "R8 one-shot retrigger");
    run_case(3, 2, 0, 3'b111, 0, 10, "R8 retrigger in delay");
    // R7 periodic sweep, with a retrigger that must be ignored
    for (int p = 2; p < 6; p++)
      for (int w = 1; w < 3; w++)
        for (int d = 0; d < 3; d += 2)
          run_case(d, w, p, 3'b111, 6, 20, "R7 R8 periodic");
    run_case(1, 4, 3, 3'b111, -5, 12, "R7 period below width");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule